// File: doc/BRIEF.md
# Chip-Bus Slot Arbiter

This block chooses, for every colour-clock slot, which master drives a shared memory bus. Four masters compete: fixed-function DMA, a display-list coprocessor, a blitter and the CPU. The blitter's micro-sequencer lives elsewhere. It gives this block a few per-slot flags: whether it is busy, whether the current micro-cycle really needs the bus, and whether it is still in its warm-up window. A blitter-priority bit and a blitter DMA enable set the policy.

When priority is set, the blitter takes every slot it needs. It also fences the CPU out of bus-free slots during warm-up, so that CPU writes cannot land inside the first holes of a blit. Once warm-up has passed, bus-free micro-cycles go back to the CPU. When priority is clear, the blitter keeps the bus until the CPU has been refused a set number of consecutive slots. It then hands over one slot. The decision is combinational within the slot-enable cycle. Only the miss counter is registered.

Top module: `chipBusSlotArbiter`

## Requirements
- R1: In a slot where fixed DMA requests the bus, the owner is fixed DMA, whatever the other inputs are.
- R2: In a slot with no fixed-DMA request, a coprocessor request wins over both the blitter and the CPU.
- R3: When the blitter is active (busy and DMA enabled) and priority is set, a slot in which the blitter needs the bus goes to the blitter, even if the CPU requests it.
- R4: When the blitter is active and priority is set, a bus-free slot with the warm-up flag high is owned by the blitter, and the CPU is refused.
- R5: When the blitter is active and priority is set, a bus-free slot after warm-up goes to the CPU if it requests it, and is otherwise idle.
- R6: When the blitter is active and priority is clear, the blitter wins the slots it needs until the CPU has been refused MISS_LIMIT (default 3) such slots in a row. The next such slot goes to the CPU, and the count then starts again from zero.
- R7: When the blitter is active and priority is clear, the blitter never owns a bus-free slot, and the warm-up flag has no effect.
- R8: The miss count returns to zero after any slot in which priority is set, or in which the blitter is not busy or its DMA is disabled.
- R9: When the blitter is not busy or its DMA is disabled, all blitter flags are ignored and a requesting CPU gets any slot not taken by fixed DMA or the coprocessor.
- R10: A slot leaves the miss count unchanged if the CPU does not request it, or if the CPU loses it to fixed DMA or the coprocessor.
- R11: In a cycle with slot enable low, the owner is zero, the grant is low, and the miss count is unchanged.
- R12: The active-low reset clears the miss count.
- R13: The owner bits mean: bit0 fixed DMA, bit1 coprocessor, bit2 blitter, bit3 CPU. At most one bit is set, all-zero means idle, and the CPU grant equals bit3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotEn | input | 1 | One pulse per colour-clock slot |
| fixedReq | input | 1 | Fixed-function DMA wants this slot |
| copReq | input | 1 | Coprocessor wants this slot |
| blitPri | input | 1 | Blitter-priority control bit |
| blitDmaEn | input | 1 | Blitter DMA enable |
| blitBusy | input | 1 | A blit is in progress |
| blitNeedsBus | input | 1 | Current blitter micro-cycle accesses memory |
| blitWarmup | input | 1 | Blitter is inside its warm-up fence window |
| cpuReq | input | 1 | CPU wants this slot |
| owner | output | 4 | One-hot slot owner, zero means idle |
| cpuGrant | output | 1 | CPU owns this slot |

## Verification
The only internal state is the miss counter. A wrong value shows up as a CPU slot that comes one or more slots early or late inside a run of blitter-owned slots without priority. The error becomes visible at the first contested slot after the corruption, and it lasts no longer than MISS_LIMIT+1 slots. For that reason, each scenario that can clear the counter, or leave it untouched, is followed by a full run of misses. The position of the yielded slot then shows the count directly.

// File: rtl/arbPkg.sv
package arbPkg;
  localparam int OWNER_W  = 4;
  localparam int OWN_FIX  = 0;
  localparam int OWN_COP  = 1;
  localparam int OWN_BLIT = 2;
  localparam int OWN_CPU  = 3;

  // strobes from control to the owner datapath
  typedef struct packed {
    logic blitActive;  // blitter busy and allowed to do DMA
    logic fenceCpu;    // warm-up fence under priority
    logic yieldOk;     // CPU has been starved long enough
  } arbStrobes_t;
endpackage

// File: rtl/arbControl.sv
module arbControl
  import arbPkg::*;
#(
  parameter int MISS_LIMIT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               slotEn,
  input  logic               blitPri,
  input  logic               blitDmaEn,
  input  logic               blitBusy,
  input  logic               blitWarmup,
  input  logic               cpuReq,
  input  logic [OWNER_W-1:0] owner,
  output arbStrobes_t        strobes
);
  localparam int CNT_W = $clog2(MISS_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MISS_LIMIT);

  logic [CNT_W-1:0] missCnt;
  logic             active;

  assign active = blitBusy & blitDmaEn;

  always_comb begin
    strobes.blitActive = active;
    strobes.fenceCpu   = active & blitPri & blitWarmup;
    strobes.yieldOk    = (missCnt == LIMIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      missCnt <= '0;
    end else if (slotEn) begin
      if (!active || blitPri) begin
        missCnt <= '0;
      end else if (owner[OWN_CPU]) begin
        missCnt <= '0;
      end else if (cpuReq && owner[OWN_BLIT] && missCnt < LIMIT) begin
        missCnt <= missCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/arbOwnerPath.sv
module arbOwnerPath
  import arbPkg::*;
(
  input  logic               slotEn,
  input  logic               fixedReq,
  input  logic               copReq,
  input  logic               blitPri,
  input  logic               blitNeedsBus,
  input  logic               cpuReq,
  input  arbStrobes_t        strobes,
  output logic [OWNER_W-1:0] owner
);
  always_comb begin
    owner = '0;
    if (slotEn) begin
      if (fixedReq) begin
        owner[OWN_FIX] = 1'b1;
      end else if (copReq) begin
        owner[OWN_COP] = 1'b1;
      end else if (strobes.blitActive) begin
        if (blitNeedsBus) begin
          if (!blitPri && cpuReq && strobes.yieldOk) owner[OWN_CPU] = 1'b1;
          else                                       owner[OWN_BLIT] = 1'b1;
        end else if (strobes.fenceCpu) begin
          owner[OWN_BLIT] = 1'b1;
        end else if (cpuReq) begin
          owner[OWN_CPU] = 1'b1;
        end
      end else if (cpuReq) begin
        owner[OWN_CPU] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/chipBusSlotArbiter.sv
module chipBusSlotArbiter
  import arbPkg::*;
#(
  parameter int MISS_LIMIT = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       slotEn,
  input  logic       fixedReq,
  input  logic       copReq,
  input  logic       blitPri,
  input  logic       blitDmaEn,
  input  logic       blitBusy,
  input  logic       blitNeedsBus,
  input  logic       blitWarmup,
  input  logic       cpuReq,
  output logic [3:0] owner,
  output logic       cpuGrant
);
  arbStrobes_t strobes;
  logic [OWNER_W-1:0] ownerInt;

  arbControl #(.MISS_LIMIT(MISS_LIMIT)) ctrl (
    .clk(clk), .rstN(rstN), .slotEn(slotEn), .blitPri(blitPri),
    .blitDmaEn(blitDmaEn), .blitBusy(blitBusy), .blitWarmup(blitWarmup),
    .cpuReq(cpuReq), .owner(ownerInt), .strobes(strobes)
  );

  arbOwnerPath path (
    .slotEn(slotEn), .fixedReq(fixedReq), .copReq(copReq), .blitPri(blitPri),
    .blitNeedsBus(blitNeedsBus), .cpuReq(cpuReq), .strobes(strobes),
    .owner(ownerInt)
  );

  assign owner    = ownerInt;
  assign cpuGrant = ownerInt[OWN_CPU];
endmodule

// File: rtl/chipBusSlotArbiterChecker.sv
module chipBusSlotArbiterChecker #(
  parameter int MISS_LIMIT = 3
) (
  input logic       clk,
  input logic       rstN,
  input logic       slotEn,
  input logic       fixedReq,
  input logic       copReq,
  input logic       blitPri,
  input logic       blitDmaEn,
  input logic       blitBusy,
  input logic       blitNeedsBus,
  input logic       blitWarmup,
  input logic       cpuReq,
  input logic [3:0] owner,
  input logic       cpuGrant
);
  localparam int SH_W = $clog2(MISS_LIMIT + 1);
  localparam logic [SH_W-1:0] SH_LIMIT = SH_W'(MISS_LIMIT);

  logic [SH_W-1:0] refusals;
  logic            act;
  logic            plain;

  assign act   = blitBusy & blitDmaEn;
  assign plain = slotEn & !fixedReq & !copReq & act;

  // independent tally of consecutive CPU refusals by the blitter
  always_ff @(posedge clk) begin
    if (!rstN) refusals <= '0;
    else if (slotEn) begin
      if (!act || blitPri || cpuGrant) refusals <= '0;
      else if (cpuReq && owner == 4'b0100 && refusals < SH_LIMIT)
        refusals <= refusals + 1'b1;
    end
  end

  assert_owner_onehot_R13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(owner) && (cpuGrant == owner[3]));
  assert_fixed_wins_R1: assert property (@(posedge clk) disable iff (!rstN)
    (slotEn && fixedReq) |-> owner == 4'b0001);
  assert_pri_need_R3: assert property (@(posedge clk) disable iff (!rstN)
    (plain && blitPri && blitNeedsBus) |-> owner == 4'b0100);
  assert_pri_fence_R4: assert property (@(posedge clk) disable iff (!rstN)
    (plain && blitPri && blitWarmup) |-> !cpuGrant);
  assert_no_pri_free_R7: assert property (@(posedge clk) disable iff (!rstN)
    (plain && !blitPri && !blitNeedsBus) |-> !owner[2]);
  assert_yield_when_starved_R6: assert property (@(posedge clk) disable iff (!rstN)
    (plain && !blitPri && blitNeedsBus && cpuReq && refusals == SH_LIMIT) |-> cpuGrant);
  assert_no_early_yield_R6: assert property (@(posedge clk) disable iff (!rstN)
    (plain && !blitPri && blitNeedsBus && refusals != SH_LIMIT) |-> !cpuGrant);
  assert_idle_off_slot_R11: assert property (@(posedge clk) disable iff (!rstN)
    !slotEn |-> owner == 4'b0000);
endmodule

bind chipBusSlotArbiter chipBusSlotArbiterChecker #(.MISS_LIMIT(MISS_LIMIT)) chk (.*);

// File: tb/chipBusSlotArbiter_test.sv
`timescale 1ns/100ps
module chipBusSlotArbiter_test;
  localparam logic [3:0] O_IDLE = 4'b0000;
  localparam logic [3:0] O_FIX  = 4'b0001;
  localparam logic [3:0] O_COP  = 4'b0010;
  localparam logic [3:0] O_BLT  = 4'b0100;
  localparam logic [3:0] O_CPU  = 4'b1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slotEn = 1'b0, fixedReq = 1'b0, copReq = 1'b0, blitPri = 1'b0;
  logic blitDmaEn = 1'b0, blitBusy = 1'b0, blitNeedsBus = 1'b0;
  logic blitWarmup = 1'b0, cpuReq = 1'b0;
  logic [3:0] owner;
  logic cpuGrant;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } expItem_t;
  expItem_t sb[$];

  always #2.5 clk = ~clk;

  chipBusSlotArbiter uut (
    .clk(clk), .rstN(rstN), .slotEn(slotEn), .fixedReq(fixedReq),
    .copReq(copReq), .blitPri(blitPri), .blitDmaEn(blitDmaEn),
    .blitBusy(blitBusy), .blitNeedsBus(blitNeedsBus), .blitWarmup(blitWarmup),
    .cpuReq(cpuReq), .owner(owner), .cpuGrant(cpuGrant)
  );

  // driver: one call per clock, inputs set on the falling edge
  task automatic slot(input logic se, input logic fx, input logic cp,
                      input logic pri, input logic en, input logic busy,
                      input logic need, input logic warm, input logic cpu,
                      input logic [3:0] exp, input string tag);
    expItem_t it;
    @(negedge clk);
    rstN = 1'b1; slotEn = se; fixedReq = fx; copReq = cp; blitPri = pri;
    blitDmaEn = en; blitBusy = busy; blitNeedsBus = need;
    blitWarmup = warm; cpuReq = cpu;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic resetCycle(input string tag);
    expItem_t it;
    @(negedge clk);
    rstN = 1'b0; slotEn = 1'b0; cpuReq = 1'b1;
    it.exp = O_IDLE; it.tag = tag;
    sb.push_back(it);
  endtask

  // contested slot without priority: blitter needs bus, CPU asks
  task automatic miss(input string tag);
    slot(1, 0, 0, 0, 1, 1, 1, 0, 1, O_BLT, tag);
  endtask
  task automatic yieldSlot(input string tag);
    slot(1, 0, 0, 0, 1, 1, 1, 0, 1, O_CPU, tag);
  endtask

  // monitor: compares 1 ns after each falling edge
  initial begin
    expItem_t it;
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        checks++;
        if (owner !== it.exp || cpuGrant !== it.exp[3]) begin
          failures++;
          $display("FAIL %s: owner=%b grant=%b expected owner=%b grant=%b",
                   it.tag, owner, cpuGrant, it.exp, it.exp[3]);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    resetCycle("R12"); resetCycle("R12");
    // R1: fixed DMA always wins
    slot(1, 1, 1, 1, 1, 1, 1, 1, 1, O_FIX, "R1");
    slot(1, 1, 0, 0, 0, 0, 0, 0, 0, O_FIX, "R1");
    // R2: coprocessor next
    slot(1, 0, 1, 1, 1, 1, 1, 0, 1, O_COP, "R2");
    slot(1, 0, 1, 0, 0, 0, 0, 0, 1, O_COP, "R2");
    // R3: priority, bus-needing slot
    slot(1, 0, 0, 1, 1, 1, 1, 0, 1, O_BLT, "R3");
    slot(1, 0, 0, 1, 1, 1, 1, 1, 0, O_BLT, "R3");
    // R4: warm-up fence
    slot(1, 0, 0, 1, 1, 1, 0, 1, 1, O_BLT, "R4");
    slot(1, 0, 0, 1, 1, 1, 0, 1, 0, O_BLT, "R4");
    // R5: bus-free after warm-up under priority
    slot(1, 0, 0, 1, 1, 1, 0, 0, 1, O_CPU, "R5");
    slot(1, 0, 0, 1, 1, 1, 0, 0, 0, O_IDLE, "R5");
    // R6: starvation yield, then the count restarts
    miss("R6"); miss("R6"); miss("R6"); yieldSlot("R6"); miss("R6");
    // R7: bus-free without priority, warm-up ignored
    slot(1, 0, 0, 0, 1, 1, 0, 1, 1, O_CPU, "R7");
    slot(1, 0, 0, 0, 1, 1, 0, 0, 0, O_IDLE, "R7");
    // R10: non-requesting and fixed-refused slots do not count
    miss("R10"); miss("R10");
    slot(1, 0, 0, 0, 1, 1, 1, 0, 0, O_BLT, "R10");
    slot(1, 1, 0, 0, 1, 1, 1, 0, 1, O_FIX, "R10");
    slot(1, 0, 1, 0, 1, 1, 1, 0, 1, O_COP, "R10");
    miss("R10"); yieldSlot("R10");
    // R8: priority slot clears the count
    miss("R8"); miss("R8");
    slot(1, 0, 0, 1, 1, 1, 1, 0, 0, O_BLT, "R8");
    miss("R8"); miss("R8"); miss("R8"); yieldSlot("R8");
    // R8: DMA disabled clears the count
    miss("R8"); miss("R8");
    slot(1, 0, 0, 0, 0, 1, 1, 0, 0, O_IDLE, "R8");
    miss("R8"); miss("R8"); miss("R8"); yieldSlot("R8");
    // R8: not busy clears the count
    miss("R8"); miss("R8");
    slot(1, 0, 0, 0, 1, 0, 1, 0, 0, O_IDLE, "R8");
    miss("R8"); miss("R8"); miss("R8"); yieldSlot("R8");
    // R9: inactive blitter flags ignored
    slot(1, 0, 0, 1, 1, 0, 1, 1, 1, O_CPU, "R9");
    slot(1, 0, 0, 1, 0, 1, 1, 1, 1, O_CPU, "R9");
    slot(1, 0, 0, 1, 0, 1, 1, 1, 0, O_IDLE, "R9");
    // R11: disabled slot gives nothing and keeps the count
    miss("R11"); miss("R11");
    slot(0, 0, 0, 0, 1, 1, 1, 0, 1, O_IDLE, "R11");
    slot(0, 1, 0, 1, 1, 1, 1, 1, 1, O_IDLE, "R11");
    miss("R11"); yieldSlot("R11");
    // R12: reset in the middle of a run clears the count
    miss("R12"); miss("R12");
    resetCycle("R12");
    miss("R12"); miss("R12"); miss("R12"); yieldSlot("R12");
    // R13: encoding covered by every check; one more idle sample
    slot(1, 0, 0, 0, 0, 0, 0, 0, 0, O_IDLE, "R13");
    @(negedge clk);
    slotEn = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule